// File: doc/BRIEF.md
# Register-Mapped Serial Port

A byte-wide asynchronous serial transmitter and receiver behind a small register bus with single-cycle reads and writes. Software writes bytes to a transmit data register and reads received bytes from a receive data register. A status register reports the line state and sticky error conditions. A control register holds one interrupt enable per status flag, plus a transmit-break control and the RTS line level. A divisor register sets the number of system clocks per bit. An end-of-packet register holds a byte value that raises a flag when that value is sent or received.

Each direction holds one byte: a holding register ahead of the transmit shifter, and a result register behind the receive shifter. Frames are fixed at one start bit, 8 data bits sent LSB first, an optional parity bit chosen at build time (none, even or odd), and one stop bit. The default build uses even parity. The single interrupt output is level-sensitive. It is high while any status flag is set whose enable bit is also set.

Top module: `sio_port`

## Requirements
- R1: After reset, status reads 0x0060 (transmit ready at bit 6 and shifter empty at bit 5, all else 0 with CTS low), control reads 0, divisor reads DIV_RST, and irq_o is low. The registers sit at byte address 0 (receive data), 4 (transmit data), 8 (status), 12 (control), 16 (divisor) and 20 (end-of-packet), decoded on addr_i[4:2].
- R2: A byte written at address 4 leaves txd_o as a low start bit, then 8 data bits LSB first, then the even-parity bit (XOR of the data), then a high stop bit. Each bit lasts the divisor value in clock cycles, and the divisor value reads back as written. txd_o is high while the transmitter is idle.
- R3: Status bit 6 (transmit ready) is clear from a transmit write until the byte moves into the shifter. Status bit 5 (empty) is set only when both the holding register and the shifter are idle. A transmit write while bit 6 is clear sets sticky bit 4 (transmit overrun) and discards the byte.
- R4: A complete received frame sets status bit 7 (receive ready). A read at address 0 returns the byte and clears bit 7.
- R5: A frame that completes while bit 7 is still set sets sticky bit 3 (receive overrun), and the newer byte replaces the older one.
- R6: A received parity bit that does not match sets sticky bit 0. A stop bit sampled low sets sticky bit 1 (framing).
- R7: A line held low through a whole frame, stop bit included, sets sticky bit 2 (break) together with bit 1.
- R8: Status bit 8 reads as the OR of bits 0 to 4. Any write at address 8 clears bits 0 to 4, 10 and 12.
- R9: Status bit 11 follows cts_i through a two-flop synchronizer. Any change of the synchronized level sets sticky bit 10.
- R10: Status bit 12 is set when a byte equal to the low 8 bits of the end-of-packet register is moved into the transmit shifter or is received.
- R11: irq_o is high exactly when a status bit among 0 to 8, 10 and 12 is set together with the control bit at the same position. Control bits 9 and 11 never raise irq_o.
- R12: Control bit 9 holds txd_o low. Control bit 11 drives rts_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | DATA_W | Write data |
| rd_i | input | 1 | Read strobe; a read side effect happens on the clock edge |
| rdata_o | output | DATA_W | Read data, combinational from addr_i |
| irq_o | output | 1 | Level interrupt |
| txd_o | output | 1 | Serial transmit line |
| rts_o | output | 1 | Request-to-send line |
| rxd_i | input | 1 | Serial receive line |
| cts_i | input | 1 | Clear-to-send line |

## Verification
The hardest condition to reach from the ports is a transmit overrun: the bench must write a second byte while the first one is still shifting out, so that the holding register is full, and then write a third byte. A scoreboard checks the frame decoded from txd_o and confirms that the third byte never appears on the line. Receive overrun, break and framing faults are produced by a line driver that shapes each received frame bit by bit: it can corrupt the parity bit, pull the stop bit low, or hold the line low for longer than a frame.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned W_RXD  = 0;
  localparam int unsigned W_TXD  = 1;
  localparam int unsigned W_STAT = 2;
  localparam int unsigned W_CTRL = 3;
  localparam int unsigned W_DIV  = 4;
  localparam int unsigned W_EOP  = 5;

  localparam int unsigned SB_PE   = 0;
  localparam int unsigned SB_FE   = 1;
  localparam int unsigned SB_BRK  = 2;
  localparam int unsigned SB_ROE  = 3;
  localparam int unsigned SB_TOE  = 4;
  localparam int unsigned SB_TMT  = 5;
  localparam int unsigned SB_TRDY = 6;
  localparam int unsigned SB_RRDY = 7;
  localparam int unsigned SB_EXC  = 8;
  localparam int unsigned SB_DCTS = 10;
  localparam int unsigned SB_CTS  = 11;
  localparam int unsigned SB_EOP  = 12;
  localparam int unsigned CB_TBRK = 9;
  localparam int unsigned CB_RTS  = 11;

  localparam int unsigned ST_W = 13;
  localparam logic [ST_W-1:0] IRQ_MASK = 13'h15FF;

  typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD} par_e;

  function automatic logic par_bit(par_e p, logic [7:0] d);
    return (p == PAR_ODD) ? ~^d : ^d;
  endfunction
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter logic RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1  <= RST;
      q_o <= RST;
    end else begin
      s1  <= d_i;
      q_o <= s1;
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter par_e        PARITY = PAR_EVEN,
  parameter int unsigned NF     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             wr_i,
  input  logic [7:0]       data_i,
  input  logic             brk_i,
  output logic             txd_o,
  output logic             full_o,
  output logic             busy_o,
  output logic             load_o,
  output logic [7:0]       load_byte_o
);
  localparam int unsigned LW = $clog2(NF + 1);

  logic [7:0]       hold;
  logic [NF-1:0]    sh, frame_w;
  logic [DIV_W-1:0] cnt;
  logic [LW-1:0]    left;

  always_comb begin
    frame_w      = '1;
    frame_w[0]   = 1'b0;
    frame_w[8:1] = hold;
    if (PARITY != PAR_NONE) frame_w[9] = par_bit(PARITY, hold);
  end

  assign load_o      = full_o && !busy_o;
  assign load_byte_o = hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold   <= '0;
      full_o <= 1'b0;
      busy_o <= 1'b0;
      sh     <= '1;
      cnt    <= '0;
      left   <= '0;
    end else begin
      if (load_o) begin
        sh     <= frame_w;
        busy_o <= 1'b1;
        cnt    <= div_i - 1'b1;
        left   <= LW'(NF - 1);
        full_o <= 1'b0;
      end else if (busy_o) begin
        if (cnt == '0) begin
          if (left == '0) begin
            busy_o <= 1'b0;
          end else begin
            sh   <= {1'b1, sh[NF-1:1]};
            left <= left - 1'b1;
            cnt  <= div_i - 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (wr_i && !full_o) begin
        hold   <= data_i;
        full_o <= 1'b1;
      end
    end
  end

  assign txd_o = brk_i ? 1'b0 : (busy_o ? sh[0] : 1'b1);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter par_e        PARITY = PAR_EVEN,
  parameter int unsigned NF     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  output logic             done_o,
  output logic [7:0]       byte_o,
  output logic             pe_o,
  output logic             fe_o,
  output logic             brk_o
);
  localparam int unsigned IW = $clog2(NF);

  logic             run, rx_q;
  logic [DIV_W-1:0] cnt;
  logic [IW-1:0]    idx;
  logic [NF-1:0]    sh, frame_w;

  assign frame_w = {rxd_i, sh[NF-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run    <= 1'b0;
      rx_q   <= 1'b1;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '1;
      done_o <= 1'b0;
      byte_o <= '0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      rx_q   <= rxd_i;
      done_o <= 1'b0;
      if (!run) begin
        if (rx_q && !rxd_i) begin
          run <= 1'b1;
          cnt <= (div_i >> 1) - 1'b1;
          idx <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= div_i - 1'b1;
        sh  <= frame_w;
        if (idx == '0 && rxd_i) begin
          run <= 1'b0;                       // start bit glitch
        end else if (idx == IW'(NF - 1)) begin
          run    <= 1'b0;
          done_o <= 1'b1;
          byte_o <= frame_w[8:1];
          fe_o   <= !rxd_i;
          brk_o  <= (frame_w == '0);
          pe_o   <= (PARITY != PAR_NONE) &&
                    (frame_w[9] != par_bit(PARITY, frame_w[8:1]));
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 16,
  parameter par_e        PARITY  = PAR_EVEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              txd_o,
  output logic              rts_o,
  input  logic              rxd_i,
  input  logic              cts_i
);
  localparam int unsigned NF = (PARITY == PAR_NONE) ? 10 : 11;

  logic [2:0]       word;
  logic             wr_tx, wr_st, wr_ct, wr_dv, wr_ep, rd_rx;
  logic [ST_W-1:0]  ctrl;
  logic [DIV_W-1:0] div_q, div_eff;
  logic [7:0]       eop_q, rx_data;
  logic             rrdy, pe, fe, brk, roe, toe, dcts, eopf;
  logic             rxd_s, cts_s, cts_q;
  logic             tx_full, tx_busy, tx_load;
  logic [7:0]       tx_byte;
  logic             rx_done, rx_pe, rx_fe, rx_brk;
  logic [7:0]       rx_byte;
  logic [ST_W-1:0]  status;

  assign word  = addr_i[4:2];
  assign wr_tx = wr_i && word == 3'(W_TXD);
  assign wr_st = wr_i && word == 3'(W_STAT);
  assign wr_ct = wr_i && word == 3'(W_CTRL);
  assign wr_dv = wr_i && word == 3'(W_DIV);
  assign wr_ep = wr_i && word == 3'(W_EOP);
  assign rd_rx = rd_i && word == 3'(W_RXD);

  assign div_eff = (div_q < DIV_W'(2)) ? DIV_W'(2) : div_q;

  sio_sync #(.RST(1'b1)) u_rxd_sync (.clk_i, .rst_ni, .d_i(rxd_i), .q_o(rxd_s));
  sio_sync #(.RST(1'b0)) u_cts_sync (.clk_i, .rst_ni, .d_i(cts_i), .q_o(cts_s));

  sio_tx #(.DIV_W(DIV_W), .PARITY(PARITY), .NF(NF)) u_tx (
    .clk_i, .rst_ni, .div_i(div_eff), .wr_i(wr_tx), .data_i(wdata_i[7:0]),
    .brk_i(ctrl[CB_TBRK]), .txd_o, .full_o(tx_full), .busy_o(tx_busy),
    .load_o(tx_load), .load_byte_o(tx_byte)
  );

  sio_rx #(.DIV_W(DIV_W), .PARITY(PARITY), .NF(NF)) u_rx (
    .clk_i, .rst_ni, .div_i(div_eff), .rxd_i(rxd_s), .done_o(rx_done),
    .byte_o(rx_byte), .pe_o(rx_pe), .fe_o(rx_fe), .brk_o(rx_brk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl  <= '0;
      div_q <= DIV_W'(DIV_RST);
      eop_q <= '0;
    end else begin
      if (wr_ct) ctrl  <= wdata_i[ST_W-1:0];
      if (wr_dv) div_q <= wdata_i[DIV_W-1:0];
      if (wr_ep) eop_q <= wdata_i[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data <= '0;
      rrdy    <= 1'b0;
      pe      <= 1'b0;
      fe      <= 1'b0;
      brk     <= 1'b0;
      roe     <= 1'b0;
      toe     <= 1'b0;
      dcts    <= 1'b0;
      eopf    <= 1'b0;
      cts_q   <= 1'b0;
    end else begin
      cts_q <= cts_s;
      pe    <= (pe   && !wr_st) || (rx_done && rx_pe);
      fe    <= (fe   && !wr_st) || (rx_done && rx_fe);
      brk   <= (brk  && !wr_st) || (rx_done && rx_brk);
      roe   <= (roe  && !wr_st) || (rx_done && rrdy && !rd_rx);
      toe   <= (toe  && !wr_st) || (wr_tx && tx_full);
      dcts  <= (dcts && !wr_st) || (cts_s != cts_q);
      eopf  <= (eopf && !wr_st) || (rx_done && rx_byte == eop_q) ||
               (tx_load && tx_byte == eop_q);
      if (rx_done) begin
        rx_data <= rx_byte;
        rrdy    <= 1'b1;
      end else if (rd_rx) begin
        rrdy <= 1'b0;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[SB_PE]   = pe;
    status[SB_FE]   = fe;
    status[SB_BRK]  = brk;
    status[SB_ROE]  = roe;
    status[SB_TOE]  = toe;
    status[SB_TMT]  = !tx_full && !tx_busy;
    status[SB_TRDY] = !tx_full;
    status[SB_RRDY] = rrdy;
    status[SB_EXC]  = pe | fe | brk | roe | toe;
    status[SB_DCTS] = dcts;
    status[SB_CTS]  = cts_s;
    status[SB_EOP]  = eopf;
  end

  assign irq_o = |(status & ctrl & IRQ_MASK);
  assign rts_o = ctrl[CB_RTS];

  always_comb begin
    rdata_o = '0;
    case (word)
      3'(W_RXD):  rdata_o[7:0]       = rx_data;
      3'(W_STAT): rdata_o[ST_W-1:0]  = status;
      3'(W_CTRL): rdata_o[ST_W-1:0]  = ctrl;
      3'(W_DIV):  rdata_o[DIV_W-1:0] = div_q;
      3'(W_EOP):  rdata_o[7:0]       = eop_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              txd_o,
  input logic              rts_o,
  input logic [12:0]       status,
  input logic [12:0]       ctrl,
  input logic              rx_done
);
  logic [2:0] w;
  assign w = addr_i[4:2];

  // R3: a transmit write into a free holding register drops ready
  p_trdy_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && w == 3'd1 && status[6]) |=> !status[6]);

  // R3: empty implies ready
  p_tmt_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[5] |-> status[6]);

  // R4: reading receive data clears receive ready
  p_rrdy_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && w == 3'd0 && !rx_done) |=> !status[7]);

  // R8: a status write clears the error flags
  p_err_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && w == 3'd2 && !rx_done) |=> (status[4:0] == 5'd0));

  // R2: idle line is high
  p_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[5] && !ctrl[9]) |-> txd_o);

  // R12: forced break holds the line low
  p_tbrk_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[9] |-> !txd_o);

  // R12: rts follows the last control write
  p_rts_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && w == 3'd3) |=> (rts_o == $past(wdata_i[11])));

  // R11: no enables, no interrupt
  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl == 13'd0) |-> !irq_o);
endmodule

bind sio_port sio_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .txd_o(txd_o), .rts_o(rts_o),
  .status(status), .ctrl(ctrl), .rx_done(rx_done)
);

// File: tb/sim_sio_port.sv
module sim_sio_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, txd_o, rts_o;
  logic        rxd_i = 1'b1, cts_i = 1'b0;

  always #2 clk = ~clk;

  sio_port u0 (
    .clk_i(clk), .rst_ni, .addr_i, .wr_i, .wdata_i, .rd_i, .rdata_o,
    .irq_o, .txd_o, .rts_o, .rxd_i, .cts_i
  );

  int n_chk = 0, n_bad = 0;
  int bd = 20;
  bit mon_en = 1'b1;
  bit ended = 1'b0;
  logic [7:0] txq[$];

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic send_tx(logic [7:0] b, bit expect_out);
    if (expect_out) txq.push_back(b);
    wr(5'd4, {8'h00, b});
  endtask

  task automatic rx_frame(logic [7:0] b, bit bad_par, bit stop);
    @(negedge clk); rxd_i = 1'b0;
    repeat (bd) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_i = b[i];
      repeat (bd) @(negedge clk);
    end
    rxd_i = (^b) ^ bad_par;
    repeat (bd) @(negedge clk);
    rxd_i = stop;
    repeat (bd) @(negedge clk);
    rxd_i = 1'b1;
    repeat (bd) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && txq.size() != 0; i++) @(negedge clk);
    repeat (bd * 2) @(negedge clk);
    chk("R2 scoreboard empty", 16'(txq.size()), 16'd0);
  endtask

  // monitor: decodes frames on txd_o and compares against the queue
  initial begin
    logic [7:0] b;
    logic p, s;
    forever begin
      @(negedge clk);
      if (mon_en && txd_o === 1'b0) begin
        repeat (bd / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bd) @(negedge clk);
          b[i] = txd_o;
        end
        repeat (bd) @(negedge clk); p = txd_o;
        repeat (bd) @(negedge clk); s = txd_o;
        if (txq.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R3: unexpected frame %h expected none", b);
        end else begin
          chk("R2 tx byte", {8'h00, b}, {8'h00, txq.pop_front()});
        end
        chk("R2 tx parity", {15'd0, p}, {15'd0, ^b});
        chk("R2 tx stop", {15'd0, s}, 16'd1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(5'd8, d);  chk("R1 status", d, 16'h0060);
    rd(5'd12, d); chk("R1 control", d, 16'h0000);
    rd(5'd16, d); chk("R1 divisor", d, 16'd16);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    wr(5'd8, 16'h0); wr(5'd12, 16'h0);
    chk("R1 irq after zero writes", {15'd0, irq_o}, 16'd0);

    // R2 divisor and transmit frames
    wr(5'd16, 16'(bd));
    rd(5'd16, d); chk("R2 divisor readback", d, 16'(bd));
    wr(5'd20, 16'h007E);
    send_tx(8'hA5, 1'b1);
    repeat (4) @(negedge clk);
    rd(5'd8, d); chk("R3 ready while shifting", d & 16'h0060, 16'h0040);
    send_tx(8'h3C, 1'b1);
    rd(5'd8, d); chk("R3 holding full", d & 16'h0060, 16'h0000);
    send_tx(8'hF0, 1'b0);
    rd(5'd8, d); chk("R3 tx overrun", d & 16'h011F, 16'h0110);
    drain();
    rd(5'd8, d); chk("R3 idle after drain", d & 16'h0060, 16'h0060);

    // R8 clear
    wr(5'd8, 16'h0);
    rd(5'd8, d); chk("R8 clear errors", d & 16'h151F, 16'h0000);

    // R10 transmit end-of-packet
    send_tx(8'h7E, 1'b1);
    repeat (6) @(negedge clk);
    rd(5'd8, d); chk("R10 eop on tx", d & 16'h1000, 16'h1000);
    drain();
    wr(5'd8, 16'h0);

    // R4 receive
    rx_frame(8'h5A, 1'b0, 1'b1);
    rd(5'd8, d); chk("R4 rx ready", d & 16'h019F, 16'h0080);
    chk("R11 irq masked", {15'd0, irq_o}, 16'd0);
    wr(5'd12, 16'h0080);
    chk("R11 irq rx ready", {15'd0, irq_o}, 16'd1);
    wr(5'd12, 16'h0);
    rd(5'd0, d); chk("R4 rx data", d, 16'h005A);
    rd(5'd8, d); chk("R4 ready cleared", d & 16'h0080, 16'h0000);

    // R5 receive overrun
    rx_frame(8'h11, 1'b0, 1'b1);
    rx_frame(8'h22, 1'b0, 1'b1);
    rd(5'd8, d); chk("R5 rx overrun", d & 16'h0188, 16'h0188);
    rd(5'd0, d); chk("R5 newest byte kept", d, 16'h0022);
    wr(5'd8, 16'h0);

    // R6 parity and framing
    rx_frame(8'h33, 1'b1, 1'b1);
    rd(5'd8, d); chk("R6 parity error", d & 16'h0107, 16'h0101);
    rd(5'd0, d); wr(5'd8, 16'h0);
    rx_frame(8'h44, 1'b0, 1'b0);
    rd(5'd8, d); chk("R6 framing error", d & 16'h0107, 16'h0102);
    rd(5'd0, d); wr(5'd8, 16'h0);

    // R7 break
    @(negedge clk); rxd_i = 1'b0;
    repeat (bd * 13) @(negedge clk);
    rxd_i = 1'b1;
    repeat (bd * 2) @(negedge clk);
    rd(5'd8, d); chk("R7 break", d & 16'h0106, 16'h0106);
    rd(5'd0, d); wr(5'd8, 16'h0);

    // R10 receive end-of-packet
    rx_frame(8'h7E, 1'b0, 1'b1);
    rd(5'd8, d); chk("R10 eop on rx", d & 16'h1000, 16'h1000);
    rd(5'd0, d); wr(5'd8, 16'h0);

    // R9 cts tracking
    cts_i = 1'b1;
    repeat (4) @(negedge clk);
    rd(5'd8, d); chk("R9 cts level and change", d & 16'h0C00, 16'h0C00);
    wr(5'd8, 16'h0);
    rd(5'd8, d); chk("R9 change cleared", d & 16'h0C00, 16'h0800);
    wr(5'd12, 16'h0400);
    chk("R11 no pending change", {15'd0, irq_o}, 16'd0);

    // R11, R12 line controls do not interrupt
    wr(5'd12, 16'h0800);
    chk("R12 rts high", {15'd0, rts_o}, 16'd1);
    chk("R11 rts bit no irq", {15'd0, irq_o}, 16'd0);
    mon_en = 1'b0;
    wr(5'd12, 16'h0200);
    repeat (2) @(negedge clk);
    chk("R12 forced break", {15'd0, txd_o}, 16'd0);
    chk("R12 rts low", {15'd0, rts_o}, 16'd0);
    chk("R11 break bit no irq", {15'd0, irq_o}, 16'd0);
    wr(5'd12, 16'h0020);
    repeat (2) @(negedge clk);
    chk("R12 line released", {15'd0, txd_o}, 16'd1);
    chk("R11 irq empty enabled", {15'd0, irq_o}, 16'd1);
    wr(5'd12, 16'h0);
    chk("R11 irq off", {15'd0, irq_o}, 16'd0);

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule